// File: doc/BRIEF.md
# Table-Driven AES-128 Round Engine

This block encrypts 128-bit blocks with AES-128. It keeps the working state as four 32-bit words. Every full round builds each new word from four table lookups and one round-key word, XORed together. Each lookup is indexed by a byte taken from a different state word, in a rotating pattern. Only the base table is formed, and it is computed as combinational logic. The other three tables are byte rotations of that base entry. The last round has no column mixing, so it uses plain substitution bytes placed in their byte lanes.

Key expansion is done outside the block. Software or a neighbouring unit writes all eleven round keys through a write port before any encryption starts. A block enters through a valid/ready handshake. The engine XORs round key 0 into the block when it accepts it, then runs ten rounds at one per clock. The ciphertext is presented on an output valid/ready handshake and is held until the consumer takes it. A new block can be accepted in the same cycle that the previous result is taken.

Top module: `aes128_tround_core`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: A clock edge with key_we high and key_idx in 0..10 stores key_data as round key key_idx. Bits 127:96 of key_data are key word 0. Writes with key_idx 11..15 are ignored and change no stored key.
- R3: out_block equals AES-128 encryption of the accepted in_block under the stored round keys. Word 0 is bits 127:96, and within a word the byte at bits 31:24 comes first. For key 000102030405060708090a0b0c0d0e0f and block 00112233445566778899aabbccddeeff the result is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: out_valid rises on the tenth rising clock edge after the edge that accepts a block.
- R5: in_ready is low while an encryption is in progress. in_valid during that time has no effect.
- R6: While out_valid is high and out_ready is low, out_valid and out_block hold their values.
- R7: in_ready is high when no encryption is running and either no result is pending or out_ready is high. This lets a result be taken and a new block be accepted on the same edge.
- R8: When a result is taken and no new block is accepted on that edge, out_valid is low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Round-key write strobe |
| key_idx | input | 4 | Round-key slot to write (0..10) |
| key_data | input | 128 | Round-key value |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Engine can accept a block |
| in_block | input | 128 | Plaintext block |
| out_valid | output | 1 | Ciphertext available |
| out_ready | input | 1 | Consumer takes the ciphertext |
| out_block | output | 128 | Ciphertext |

## Verification
Two events can share one clock edge: handing off a finished ciphertext and accepting the next plaintext. The bench sets this up in two ways. In the first, in_valid stays high and out_ready stays low, so a result is pending while a new block waits; out_ready is then raised. In the second, a long back-to-back run keeps both handshakes asserted. A behavioural byte-oriented AES model in the bench predicts in_ready, out_valid and out_block on every cycle. It expects the new block to be taken on the same edge that clears the old result, and the next result to appear ten edges later.

// File: rtl/aes128_tround_core.sv
module aes128_tround_core #(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_we,
  input  logic [3:0]   key_idx,
  input  logic [127:0] key_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_block,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_block
);
  localparam int NKEYS = ROUNDS + 1;

  logic [127:0] rkey [NKEYS];
  logic [127:0] state, nxt;
  logic [3:0]   rnd;
  logic         busy, ov;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = xt(x);
    end
    return r;
  endfunction

  function automatic logic [7:0] sub(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gmul(r, p);
      p = gmul(p, p);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] tbase(input logic [7:0] a);
    logic [7:0] s;
    s = sub(a);
    return {xt(s), s, s, xt(s) ^ s};
  endfunction

  always_ff @(posedge clk) begin
    if (key_we && key_idx < 4'(NKEYS)) rkey[key_idx] <= key_data;
  end

  always_comb begin
    logic [31:0] w [4];
    logic [31:0] t0, t1, t2, t3, kw, full, last;
    logic [7:0]  b0, b1, b2, b3;
    nxt = '0;
    for (int i = 0; i < 4; i++) w[i] = state[127-32*i -: 32];
    for (int i = 0; i < 4; i++) begin
      b0 = w[i][31:24];
      b1 = w[(i+1)%4][23:16];
      b2 = w[(i+2)%4][15:8];
      b3 = w[(i+3)%4][7:0];
      t0 = tbase(b0);
      t1 = tbase(b1);
      t2 = tbase(b2);
      t3 = tbase(b3);
      full = t0 ^ {t1[7:0], t1[31:8]} ^ {t2[15:0], t2[31:16]} ^ {t3[23:0], t3[31:24]};
      last = {sub(b0), sub(b1), sub(b2), sub(b3)};
      kw = rkey[rnd][127-32*i -: 32];
      nxt[127-32*i -: 32] = ((rnd == 4'(ROUNDS)) ? last : full) ^ kw;
    end
  end

  assign in_ready  = !busy && (!ov || out_ready);
  assign out_valid = ov;
  assign out_block = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
      rnd   <= '0;
      busy  <= 1'b0;
      ov    <= 1'b0;
    end else if (busy) begin
      state <= nxt;
      if (rnd == 4'(ROUNDS)) begin
        busy <= 1'b0;
        ov   <= 1'b1;
        rnd  <= '0;
      end else begin
        rnd <= rnd + 4'd1;
      end
    end else if (in_valid && in_ready) begin
      state <= in_block ^ rkey[0];
      rnd   <= 4'd1;
      busy  <= 1'b1;
      ov    <= 1'b0;
    end else if (ov && out_ready) begin
      ov <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rnd) == 4'(ROUNDS));

  assert_accept_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !out_valid));

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/aes128_tround_core_bench.sv
module aes128_tround_core_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, key_we, in_valid, out_ready;
  logic [3:0]   key_idx;
  logic [127:0] key_data, in_block;
  logic         in_ready, out_valid;
  logic [127:0] out_block;

  aes128_tround_core u_aes128_tround_core (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx), .key_data(key_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_block(in_block),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block)
  );

  logic [7:0]   sbox [256];
  logic [127:0] rks [11];
  int checks = 0, fails = 0;
  bit m_busy = 0, m_ov = 0;
  int m_cnt = 0;
  logic [127:0] m_pend = '0, m_out = '0;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return 8'((a << n) | (a >> (8 - n)));
  endfunction

  task automatic build_sbox();
    logic [7:0] p = 8'h01, q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'b0000};
      if (q[7]) q = q ^ 8'h09;
      sbox[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sbox[0] = 8'h63;
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sbox[t[23:16]], sbox[t[15:8]], sbox[t[7:0]], sbox[t[31:24]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] n [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rks[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sbox[s[i]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) n[w + 4*c] = s[w + 4*((c + w) % 4)];
      if (r != 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = n[4*c]; a1 = n[4*c+1]; a2 = n[4*c+2]; a3 = n[4*c+3];
          n[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          n[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          n[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          n[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = n[i] ^ rks[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic compare();
    bit rdy;
    rdy = !m_busy && (!m_ov || out_ready);
    chk(out_valid == m_ov, "R4/R8 out_valid", 128'(out_valid), 128'(m_ov));
    chk(in_ready == rdy, "R5/R7 in_ready", 128'(in_ready), 128'(rdy));
    if (m_ov) chk(out_block == m_out, "R3/R6 out_block", out_block, m_out);
  endtask

  task automatic tick();
    bit rdy, acc, take;
    rdy  = !m_busy && (!m_ov || out_ready);
    acc  = in_valid && rdy;
    take = m_ov && out_ready;
    @(posedge clk);
    #1;
    if (m_busy) begin
      m_cnt++;
      if (m_cnt == 10) begin m_busy = 0; m_ov = 1; m_out = m_pend; end
    end else begin
      if (take) m_ov = 0;
      if (acc) begin m_busy = 1; m_cnt = 0; m_ov = 0; m_pend = ref_enc(in_block); end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic load_keys(input logic [127:0] key);
    expand(key);
    for (int r = 0; r < 11; r++) begin
      key_we = 1; key_idx = 4'(r); key_data = rks[r];
      tick();
    end
    key_we = 0;
  endtask

  task automatic send(input logic [127:0] blk);
    int g = 0;
    in_valid = 1; in_block = blk;
    do begin tick(); g++; end while (!(m_busy && m_cnt == 0) && g < 50);
    in_valid = 0;
  endtask

  task automatic drain();
    int g = 0;
    while (!m_ov && g < 50) begin tick(); g++; end
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [127:0] saved;
    build_sbox();
    rst_n = 0; key_we = 0; key_idx = 0; key_data = '0;
    in_valid = 0; in_block = '0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'd1);

    // R2 R3 R4: standard vector and latency
    load_keys(128'h000102030405060708090a0b0c0d0e0f);
    out_ready = 0;
    send(128'h00112233445566778899aabbccddeeff);
    n = 0;
    while (!out_valid && n < 40) begin tick(); n++; end
    chk(n == 10, "R4 edges from accept to out_valid", 128'(n), 128'd10);
    chk(out_block == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 standard vector",
        out_block, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    saved = out_block;

    // R5 R6 R7: pending result with new block waiting, then same-edge handoff
    in_valid = 1; in_block = rnd128();
    repeat (12) tick();
    chk(out_block == saved, "R6 held under backpressure", out_block, saved);
    out_ready = 1;
    tick();
    chk(m_busy && in_ready == 0, "R7 accepted on handoff edge", 128'(in_ready), 128'd0);
    in_valid = 0;
    drain();
    tick();
    chk(out_valid == 0, "R8 out_valid dropped after take", 128'(out_valid), 128'd0);

    // R5 R7: back-to-back stream with both handshakes asserted
    in_valid = 1; in_block = rnd128();
    for (int k = 0; k < 90; k++) begin
      tick();
      if (m_busy && m_cnt == 0) in_block = rnd128();
    end
    in_valid = 0;
    drain(); tick();

    // R2: writes to slots 11..15 are ignored
    key_we = 1; key_idx = 4'd11; key_data = rnd128(); tick();
    key_idx = 4'd15; key_data = rnd128(); tick();
    key_we = 0;
    send(128'h00112233445566778899aabbccddeeff);
    drain();
    chk(out_block == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 ignored slot writes",
        out_block, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    tick();

    // R2 R3: reloaded key set, corner blocks
    load_keys({128{1'b1}});
    send('0); drain(); tick();
    send({128{1'b1}}); drain(); tick();
    load_keys('0);
    send('0); drain();
    chk(out_block == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R3 zero key zero block",
        out_block, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    tick(); tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule